// File: doc/BRIEF.md
# Read-Sequence Store/Recall Command Detector

This block sits beside a 32K x 8 memory and watches the read cycles on its 15-bit address bus. A host issues a special command by performing six reads in a fixed order. The first five reads use addresses that both commands share. The sixth address selects the command: a nonvolatile store of the SRAM contents, or a recall of the nonvolatile contents into the SRAM.

When a sequence completes, the block raises a one-cycle request for the chosen command. It also asserts `port_disable`, which cuts the memory port off for both reads and writes. The nonvolatile transfer itself lies outside this block. Its end is signalled on `op_done`, which re-enables the port.

Only chip-enable-qualified read cycles advance the match. A write cycle, or a read of an unexpected address, breaks the chain. The pins are plain control strobes and pulses. No data moves through the block, so it has no valid/ready interface and no back-pressure.

Top module: `seqcmd_detect`

## Requirements
- R1: After reset, `store_req`, `recall_req` and `port_disable` are low and the matcher is at its start.
- R2: Reads of 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F and then 0x0FC0, in this order, produce a `store_req` pulse. The pulse is high exactly in the cycle after the clock edge that samples the sixth read. Idle cycles between the reads are allowed.
- R3: The same five reads followed by a read of 0x0C63 produce a `recall_req` pulse with the same timing as R2.
- R4: `store_req` and `recall_req` are each exactly one cycle wide and are never high together.
- R5: `port_disable` rises together with the request pulse. It stays high until `op_done` is sampled high, and it is low in the cycle after that edge.
- R6: While `port_disable` is high, reads and writes are ignored and no request is produced. After `op_done`, a new command needs a full six-read sequence.
- R7: A read of an address other than the expected next one returns the matcher to its start. If that address is 0x0E38, it counts as the first step.
- R8: A write strobe returns the matcher to its start and never advances it. When `rd_stb` and `wr_stb` are sampled high together, the cycle counts as a write.
- R9: After the five shared reads, a sixth read that is neither 0x0FC0 nor 0x0C63 produces no request and restarts the matcher. A later lone read of 0x0FC0 produces nothing.
- R10: `op_done` while the port is enabled has no effect: a partially built chain continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 15 | Memory address of the current bus cycle |
| rd_stb | input | 1 | One-cycle strobe per chip-enable-qualified read cycle |
| wr_stb | input | 1 | One-cycle strobe per write cycle |
| op_done | input | 1 | Store or recall transfer has finished |
| store_req | output | 1 | One-cycle request to start a nonvolatile store |
| recall_req | output | 1 | One-cycle request to start a recall |
| port_disable | output | 1 | Memory port blocked while a transfer is outstanding |

## Verification
The embedded assertions check, on every cycle, the invariants of the requests and the lock. The two requests are exclusive and one cycle wide. `port_disable` is high with each request, holds until `op_done` and then falls, and no request appears while the port is blocked. They also check that a write clears the chain and that the chain holds still when there is no strobe. Only the bench scenarios can show which address orders yield which command. These scenarios cover restarts on a stray 0x0E38, write interruption, invalid sixth addresses, sequences ignored while locked, and the exact cycle in which each request appears.

// File: rtl/seqcmd_pkg.sv
package seqcmd_pkg;

  localparam int SEQ_STEPS = 6;
  localparam int SHARED_STEPS = SEQ_STEPS - 1;

  typedef enum logic [1:0] {
    CMD_NONE   = 2'd0,
    CMD_STORE  = 2'd1,
    CMD_RECALL = 2'd2
  } cmd_e;

  localparam logic [14:0] STORE_KEY  = 15'h0FC0;
  localparam logic [14:0] RECALL_KEY = 15'h0C63;

  // Address expected at each shared step, in sequence order.
  function automatic logic [14:0] shared_key(input int idx);
    case (idx)
      0:       shared_key = 15'h0E38;
      1:       shared_key = 15'h31C7;
      2:       shared_key = 15'h03E0;
      3:       shared_key = 15'h3C1F;
      4:       shared_key = 15'h303F;
      default: shared_key = 15'h0000;
    endcase
  endfunction

endpackage

// File: rtl/seqcmd_addr_match.sv
module seqcmd_addr_match
  import seqcmd_pkg::*;
#(
  parameter int ADDR_W   = 15,
  parameter int N_SHARED = SHARED_STEPS
) (
  input  logic [ADDR_W-1:0]   bus_addr,
  output logic [N_SHARED-1:0] hit_shared,
  output logic                hit_store,
  output logic                hit_recall
);

  // One comparator per shared step.
  for (genvar g = 0; g < N_SHARED; g++) begin : g_cmp
    assign hit_shared[g] = (bus_addr == ADDR_W'(shared_key(g)));
  end

  assign hit_store  = (bus_addr == ADDR_W'(STORE_KEY));
  assign hit_recall = (bus_addr == ADDR_W'(RECALL_KEY));

endmodule

// File: rtl/seqcmd_chain.sv
module seqcmd_chain
  import seqcmd_pkg::*;
#(
  parameter int N_SHARED = SHARED_STEPS,
  localparam int CW      = $clog2(N_SHARED + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_stb,
  input  logic                wr_stb,
  input  logic                locked,
  input  logic [N_SHARED-1:0] hit_shared,
  input  logic                hit_store,
  input  logic                hit_recall,
  output cmd_e                fire
);

  logic [CW-1:0] depth;
  logic [CW-1:0] depth_nxt;
  logic          act_rd;
  logic          act_wr;
  logic          at_final;
  logic          exp_hit;

  assign act_wr   = wr_stb && !locked;
  assign act_rd   = rd_stb && !wr_stb && !locked;
  assign at_final = (depth == CW'(N_SHARED));

  always_comb begin
    exp_hit = 1'b0;
    for (int i = 0; i < N_SHARED; i++) begin
      if (depth == CW'(i)) exp_hit = hit_shared[i];
    end
  end

  always_comb begin
    fire = CMD_NONE;
    if (act_rd && at_final) begin
      if (hit_store)       fire = CMD_STORE;
      else if (hit_recall) fire = CMD_RECALL;
    end
  end

  always_comb begin
    depth_nxt = depth;
    if (act_wr) begin
      depth_nxt = '0;
    end else if (act_rd) begin
      if (fire != CMD_NONE)        depth_nxt = '0;
      else if (!at_final && exp_hit) depth_nxt = depth + CW'(1);
      else if (hit_shared[0])      depth_nxt = CW'(1);
      else                         depth_nxt = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) depth <= '0;
    else        depth <= depth_nxt;
  end

  // R8: a write on an open port clears the chain
  assert_write_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !locked) |=> (depth == '0));

  // R10: with no strobe the chain holds, whatever op_done does
  assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb && !wr_stb) |=> $stable(depth));

  // R6: the chain sits at its start while the port is blocked
  assert_locked_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (depth == '0));

  // R7: depth never exceeds the final step
  assert_depth_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= CW'(N_SHARED));

endmodule

// File: rtl/seqcmd_guard.sv
module seqcmd_guard
  import seqcmd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cmd_e fire,
  input  logic op_done,
  output logic store_req,
  output logic recall_req,
  output logic port_disable
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_req    <= 1'b0;
      recall_req   <= 1'b0;
      port_disable <= 1'b0;
    end else begin
      store_req  <= (fire == CMD_STORE);
      recall_req <= (fire == CMD_RECALL);
      if (fire != CMD_NONE)
        port_disable <= 1'b1;
      else if (port_disable && op_done)
        port_disable <= 1'b0;
    end
  end

  assert_req_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(store_req && recall_req));

  assert_store_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    store_req |=> !store_req);

  assert_recall_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    recall_req |=> !recall_req);

  assert_lock_with_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (store_req || recall_req) |-> port_disable);

  assert_lock_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (port_disable && !op_done) |=> port_disable);

  assert_lock_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (port_disable && op_done) |=> !port_disable);

  assert_no_req_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    port_disable |=> !(store_req || recall_req));

endmodule

// File: rtl/seqcmd_detect.sv
module seqcmd_detect
  import seqcmd_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic              op_done,
  output logic              store_req,
  output logic              recall_req,
  output logic              port_disable
);

  localparam int N_SHARED = SHARED_STEPS;

  logic [N_SHARED-1:0] hit_shared;
  logic                hit_store;
  logic                hit_recall;
  cmd_e                fire;

  seqcmd_addr_match #(.ADDR_W(ADDR_W), .N_SHARED(N_SHARED)) u_match (
    .bus_addr   (bus_addr),
    .hit_shared (hit_shared),
    .hit_store  (hit_store),
    .hit_recall (hit_recall)
  );

  seqcmd_chain #(.N_SHARED(N_SHARED)) u_chain (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_stb     (rd_stb),
    .wr_stb     (wr_stb),
    .locked     (port_disable),
    .hit_shared (hit_shared),
    .hit_store  (hit_store),
    .hit_recall (hit_recall),
    .fire       (fire)
  );

  seqcmd_guard u_guard (
    .clk          (clk),
    .rst_n        (rst_n),
    .fire         (fire),
    .op_done      (op_done),
    .store_req    (store_req),
    .recall_req   (recall_req),
    .port_disable (port_disable)
  );

endmodule

// File: tb/test_seqcmd_detect.sv
module test_seqcmd_detect;
  import seqcmd_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] bus_addr = '0;
  logic        rd_stb = 1'b0;
  logic        wr_stb = 1'b0;
  logic        op_done = 1'b0;
  logic        store_req;
  logic        recall_req;
  logic        port_disable;

  always #2 clk = ~clk;   // 250 MHz

  seqcmd_detect i_seqcmd_detect (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .rd_stb(rd_stb),
    .wr_stb(wr_stb), .op_done(op_done), .store_req(store_req),
    .recall_req(recall_req), .port_disable(port_disable)
  );

  typedef struct { cmd_e kind; int at; } exp_t;
  exp_t  exp_q[$];
  int    n_chk = 0;
  int    n_bad = 0;
  int    cyc = 0;
  string cur_req = "R1";
  logic  prev_st = 1'b0;
  logic  prev_rc = 1'b0;

  localparam logic [14:0] A0 = 15'h0E38, A1 = 15'h31C7, A2 = 15'h03E0,
                          A3 = 15'h3C1F, A4 = 15'h303F;
  localparam logic [14:0] K_ST = 15'h0FC0, K_RC = 15'h0C63;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp_v, cyc);
    end
  endtask

  // Monitor: pops the scoreboard on each request pulse.
  always @(negedge clk) begin
    if (rst_n) begin
      check(!(store_req && recall_req), "R4", {store_req, recall_req}, 0);
      if ((store_req && prev_st) || (recall_req && prev_rc))
        check(1'b0, "R4", 2, 1);
      if (store_req || recall_req) begin
        cmd_e got;
        got = store_req ? CMD_STORE : CMD_RECALL;
        check(port_disable, "R5", port_disable, 1);
        if (exp_q.size() == 0) begin
          check(1'b0, cur_req, int'(got), int'(CMD_NONE));
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(got == e.kind, cur_req, int'(got), int'(e.kind));
          check(cyc == e.at, cur_req, cyc, e.at);
        end
      end
    end
    prev_st = store_req;
    prev_rc = recall_req;
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [14:0] a, input cmd_e expect_kind = CMD_NONE);
    @(negedge clk);
    bus_addr = a; rd_stb = 1'b1;
    if (expect_kind != CMD_NONE) exp_q.push_back('{expect_kind, cyc + 1});
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic wr(input logic [14:0] a, input bit with_rd = 0);
    @(negedge clk);
    bus_addr = a; wr_stb = 1'b1; rd_stb = with_rd;
    @(negedge clk);
    wr_stb = 1'b0; rd_stb = 1'b0;
  endtask

  task automatic shared5();
    rd(A0); rd(A1); idle(2); rd(A2); rd(A3); rd(A4);
  endtask

  task automatic done_pulse();
    @(negedge clk); op_done = 1'b1;
    @(negedge clk); op_done = 1'b0;
  endtask

  // Wait out a scenario and confirm every expected pulse arrived.
  task automatic settle(input string req);
    idle(3);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    // R1: reset state
    check({store_req, recall_req, port_disable} == 3'b000, "R1",
          {store_req, recall_req, port_disable}, 0);
    rst_n = 1'b1;
    idle(2);
    check({store_req, recall_req, port_disable} == 3'b000, "R1",
          {store_req, recall_req, port_disable}, 0);

    // R2 / R5: store, lock held, release one cycle after op_done
    cur_req = "R2";
    shared5(); rd(K_ST, CMD_STORE);
    settle("R2");
    idle(5);
    check(port_disable, "R5", port_disable, 1);
    @(negedge clk); op_done = 1'b1;
    @(negedge clk); op_done = 1'b0;
    check(!port_disable, "R5", port_disable, 0);

    // R3: recall
    cur_req = "R3";
    shared5(); rd(K_RC, CMD_RECALL);
    settle("R3");

    // R6: sequence while locked is ignored
    cur_req = "R6";
    shared5(); rd(K_RC);
    done_pulse();
    rd(K_ST);
    settle("R6");
    check(!port_disable, "R6", port_disable, 0);
    shared5(); rd(K_ST, CMD_STORE);
    settle("R6");
    done_pulse();

    // R7: stray address breaks chain; stray 0x0E38 counts as step 1
    cur_req = "R7";
    rd(A0); rd(A1); rd(15'h0123); rd(A2); rd(A3); rd(A4); rd(K_ST);
    settle("R7");
    check(!port_disable, "R7", port_disable, 0);
    rd(A0); rd(A1); rd(A2); rd(A0); rd(A1); rd(A2); rd(A3); rd(A4);
    rd(K_RC, CMD_RECALL);
    settle("R7");
    done_pulse();
    rd(A0); rd(A0); rd(A1); rd(A2); rd(A3); rd(A4); rd(K_ST, CMD_STORE);
    settle("R7");
    done_pulse();

    // R8: write interrupts; write+read together counts as write
    cur_req = "R8";
    rd(A0); rd(A1); rd(A2); wr(A3); rd(A3); rd(A4); rd(K_ST);
    settle("R8");
    rd(A0); rd(A1); rd(A2); wr(A3, 1); rd(A4); rd(K_ST);
    settle("R8");
    wr(A0); wr(A1); wr(A2); wr(A3); wr(A4); wr(K_ST);
    settle("R8");
    check(!port_disable, "R8", port_disable, 0);

    // R9: invalid sixth address, then lone key read
    cur_req = "R9";
    shared5(); rd(15'h1234); rd(K_ST);
    settle("R9");
    shared5(); rd(A4); rd(K_RC);
    settle("R9");
    check(!port_disable, "R9", port_disable, 0);

    // R10: op_done on an open port leaves the chain alone
    cur_req = "R10";
    rd(A0); rd(A1); done_pulse(); rd(A2); rd(A3); rd(A4);
    rd(K_RC, CMD_RECALL);
    settle("R10");
    done_pulse();
    check(!port_disable, "R10", port_disable, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule